// File: doc/BRIEF.md
# UART Register and Status Front End

This block is the software-visible face of a simple serial port. A word-indexed bus port reads and writes a small register file: three control words, a FIFO-control word, two status words, a test/status word, a baud modulator, a baud count and a one-millisecond scratch word. Serial bit timing, baud generation, FIFOs, DMA and modem lines live elsewhere or not at all. The baud and scratch words only hold what software writes.

The transmit side is a data port. Each accepted write produces a one-cycle strobe carrying one byte. The receive side is a single-character holding buffer. It is fed by a character input that is accepted only while the buffer is free, and by a break input that overwrites the buffer with a break code. Reading the receive word hands the character over and frees the buffer. One level interrupt combines receive-ready, transmit-ready and transmitter-empty under the enables in control word 1.

Writing control word 2 with bit 0 low triggers a soft reset of the block. A rising receive-enable bit pulses a retry output, so that a sender that was refused can offer its character again.

Top module: `uart_regfile`

## Requirements
- R1: After reset the words read as follows. Receive word 0x4000 (bit 14 error flag). Status 1 0x3040 (bit 13 transmit-ready, bit 12 RTS-state, bit 6 receiver-idle). Status 2 0x4028 (bit 14 transmit-FIFO-empty, bit 5 DCD-in, bit 3 transmit-complete). Test word 0x0060 (bit 6 TX-empty, bit 5 RX-empty). Control 1 0, control 2 0x0001, control 3 0x0700, baud modulator 0, baud count 4, FIFO control 0, millisecond word 0.
- R2: Word indices: receive 0x00, transmit 0x10, control 1 to 4 at 0x20 to 0x23, FIFO control 0x24, status 1 0x25, status 2 0x26, baud increment 0x29, baud modulator 0x2A, baud count 0x2B, millisecond word 0x2C, test word 0x2D.
- R3: A read of the receive word returns the buffer. If a character is pending, bit 15 (char-ready) is also set and the read consumes it. Status 1 bit 9 and status 2 bit 0 then clear, test bit 5 sets, and `rx_ready` rises.
- R4: `rx_ready` is high exactly while no character is pending. A character offered with `rx_valid` while it is high loads the buffer as {8'h00, char}, sets status 1 bit 9 and status 2 bit 0, and clears test bit 5. A character offered while it is low is dropped.
- R5: A `brk_evt` pulse loads 0x0800 (bit 11 break flag) into the buffer and marks it pending, even if a character is already pending.
- R6: `irq` is high when (status 1 bit 9 and control 1 bit 9) holds, or when control 1 bit 6 (TX-empty interrupt enable) is set. Transmit-ready is control-1 bit 13 gated, and TX-empty is always set, so bit 13 alone never raises `irq`.
- R7: A write to the transmit word while control 2 bit 2 (TX-enable) is set gives a one-cycle `tx_valid` on the next clock, with `tx_byte` equal to bits 7:0 of the write. Without TX-enable the write is dropped.
- R8: A control 2 write with bit 0 low returns control 1, control 3, baud modulator, baud count and the receive buffer and its flags to their R1 values. It keeps FIFO control and the millisecond word. Control 2 stores the written low 16 bits with bit 0 forced to 1.
- R9: Writes to status 1, status 2 and the test word never change any value read from them.
- R10: Control 1, 2, 3, FIFO control, baud modulator and the millisecond word store only bits 15:0 of a write. Control 4 ignores writes. Control 4, baud increment and every unmapped index read as 0.
- R11: A write to the baud increment index stores into the baud count word, read at 0x2B. Writes to 0x2B itself are ignored.
- R12: A control 2 write that sets bit 1 (RX-enable) while it was clear pulses `rx_retry` for one cycle on the next clock. In a soft-reset write the previous value counts as clear.
- R13: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Receive character offered |
| rx_char | input | 8 | Offered character |
| rx_ready | output | 1 | Buffer free, character will be taken |
| rx_retry | output | 1 | One-cycle retry pulse on RX-enable rise |
| brk_evt | input | 1 | Break event |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default ADDR_W of 10, DATA_W of 32 and REG_W of 16. The 10-bit index reaches many unmapped words above 0x2D, and those must read as zero. Because the data width is wider than the register width, random upper halves in every write exercise truncation. A reference model tracks the buffer, the flags and the interrupt across random mixes of writes, reads, offered characters, breaks and soft resets.

// File: rtl/uart_regs_pkg.sv
// Shared register indices, bit positions and reset values for the UART
// register front end. Assumes a 16-bit register width for reset constants.
package uart_regs_pkg;

    // word indices
    localparam int IDX_RXD   = 'h00;
    localparam int IDX_TXD   = 'h10;
    localparam int IDX_CTL1  = 'h20;
    localparam int IDX_CTL2  = 'h21;
    localparam int IDX_CTL3  = 'h22;
    localparam int IDX_CTL4  = 'h23;
    localparam int IDX_FIFO  = 'h24;
    localparam int IDX_STA1  = 'h25;
    localparam int IDX_STA2  = 'h26;
    localparam int IDX_BINC  = 'h29;
    localparam int IDX_BMOD  = 'h2A;
    localparam int IDX_BCNT  = 'h2B;
    localparam int IDX_MSEC  = 'h2C;
    localparam int IDX_TEST  = 'h2D;

    // receive word flags
    localparam int B_CHRDY   = 15;
    localparam logic [15:0] HOLD_RST = 16'h4000;
    localparam logic [15:0] HOLD_BRK = 16'h0800;

    // control bits
    localparam int B_RRDY_EN = 9;
    localparam int B_TRDY_EN = 13;
    localparam int B_TXE_EN  = 6;
    localparam int B_SRST_N  = 0;
    localparam int B_RXEN    = 1;
    localparam int B_TXEN    = 2;

    // status assembly
    localparam int B_RRDY    = 9;
    localparam int B_RDR     = 0;
    localparam int B_RXEMPTY = 5;
    localparam logic [15:0] STA1_FIXED = 16'h3040;
    localparam logic [15:0] STA2_FIXED = 16'h4028;
    localparam logic [15:0] TEST_FIXED = 16'h0040;

    localparam logic [15:0] CTL2_RST = 16'h0001;
    localparam logic [15:0] BCNT_RST = 16'h0004;

    // plain storage words built by a generate loop
    localparam int NUM_PLAIN = 4;

    function automatic int plain_idx(input int i);
        case (i)
            0:       return IDX_CTL3;
            1:       return IDX_FIFO;
            2:       return IDX_BMOD;
            default: return IDX_MSEC;
        endcase
    endfunction

    function automatic logic [15:0] plain_rst(input int i);
        return (i == 0) ? 16'h0700 : 16'h0000;
    endfunction

    // whether the soft reset returns this word to its reset value
    function automatic logic plain_srst(input int i);
        return (i == 0) || (i == 2);
    endfunction

endpackage

// File: rtl/uart_cfg_regs.sv
// Control and scratch word storage. Decodes writes, detects the soft reset
// request and the RX-enable rise. Assumes one access per cycle.
module uart_cfg_regs
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic              soft_rst,
    output logic              rx_retry,
    output logic [REG_W-1:0]  ctl1,
    output logic [REG_W-1:0]  ctl2,
    output logic [REG_W-1:0]  ctl3,
    output logic [REG_W-1:0]  fifo_ctl,
    output logic [REG_W-1:0]  bmod,
    output logic [REG_W-1:0]  bcnt,
    output logic [REG_W-1:0]  msec
);

    logic             wr_ctl2;
    logic [REG_W-1:0] plain_q [NUM_PLAIN];

    // decode of the control-2 write and its soft reset request
    always_comb begin
        wr_ctl2  = wr_en && (addr == ADDR_W'(IDX_CTL2));
        soft_rst = wr_ctl2 && !wdata[B_SRST_N];
    end

    // control word 1: enables, cleared by any reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                        ctl1 <= '0;
        else if (wr_en && addr == ADDR_W'(IDX_CTL1))   ctl1 <= wdata;
    end

    // control word 2: stored with the soft reset bit forced high
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl2 <= REG_W'(CTL2_RST);
        else if (wr_ctl2)  ctl2 <= wdata | REG_W'(1 << B_SRST_N);
    end

    // baud count: loaded through the increment index
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)                        bcnt <= REG_W'(BCNT_RST);
        else if (wr_en && addr == ADDR_W'(IDX_BINC))   bcnt <= wdata;
    end

    // RX-enable rise pulse; a soft reset clears the old enable first
    always_ff @(posedge clk) begin
        if (!rst_n) rx_retry <= 1'b0;
        else        rx_retry <= wr_ctl2 && wdata[B_RXEN] && (soft_rst || !ctl2[B_RXEN]);
    end

    for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
        // one plain storage word with optional soft reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                plain_q[g] <= REG_W'(plain_rst(g));
            else if (soft_rst && plain_srst(g))
                plain_q[g] <= REG_W'(plain_rst(g));
            else if (wr_en && addr == ADDR_W'(plain_idx(g)))
                plain_q[g] <= wdata;
        end
    end

    // name the plain words for the read mux
    always_comb begin
        ctl3     = plain_q[0];
        fifo_ctl = plain_q[1];
        bmod     = plain_q[2];
        msec     = plain_q[3];
    end

endmodule

// File: rtl/uart_rx_hold.sv
// One-character receive holding buffer with its pending flag. Assumes the
// sender only offers a character while rx_ready is seen high.
module uart_rx_hold
    import uart_regs_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              take,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              brk_evt,
    output logic [REG_W-1:0]  hold,
    output logic              pending,
    output logic              rx_ready
);

    // buffer free indication
    always_comb rx_ready = !pending;

    // load, break overwrite and consume of the held character
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            hold    <= REG_W'(HOLD_RST);
            pending <= 1'b0;
        end else if (brk_evt) begin
            hold    <= REG_W'(HOLD_BRK);
            pending <= 1'b1;
        end else if (rx_valid && !pending) begin
            hold    <= REG_W'(rx_char);
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_gen.sv
// Interrupt combiner: ready flags under their enables, transmit-ready and
// TX-empty both gated by the TX-empty enable. Purely combinational.
module uart_irq_gen
    import uart_regs_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] ctl1,
    input  logic             rx_rdy,
    input  logic             tx_rdy,
    input  logic             tx_empty,
    output logic             irq
);

    // level interrupt from flags and enables
    always_comb begin
        irq = (rx_rdy && ctl1[B_RRDY_EN])
            || (ctl1[B_TXE_EN] && ((tx_rdy && ctl1[B_TRDY_EN]) || tx_empty));
    end

endmodule

// File: rtl/uart_regfile.sv
// UART register front end: word-indexed register file, transmit strobe,
// receive buffer handshake and level interrupt. Assumes bus_addr is a word
// index and that bus_rd and bus_wr share that index in a cycle.
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    output logic              rx_ready,
    output logic              rx_retry,
    input  logic              brk_evt,
    output logic              irq
);

    localparam logic TX_RDY_FLAG   = 1'b1;
    localparam logic TX_EMPTY_FLAG = 1'b1;

    logic             soft_rst, pending, take, tx_fire;
    logic [REG_W-1:0] ctl1, ctl2, ctl3, fifo_ctl, bmod, bcnt, msec, hold;
    logic [REG_W-1:0] rd_word;

    uart_cfg_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[REG_W-1:0]), .soft_rst(soft_rst), .rx_retry(rx_retry),
        .ctl1(ctl1), .ctl2(ctl2), .ctl3(ctl3), .fifo_ctl(fifo_ctl),
        .bmod(bmod), .bcnt(bcnt), .msec(msec)
    );

    uart_rx_hold #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .take(take),
        .rx_valid(rx_valid), .rx_char(rx_char), .brk_evt(brk_evt),
        .hold(hold), .pending(pending), .rx_ready(rx_ready)
    );

    uart_irq_gen #(.REG_W(REG_W)) u_irq (
        .ctl1(ctl1), .rx_rdy(pending), .tx_rdy(TX_RDY_FLAG),
        .tx_empty(TX_EMPTY_FLAG), .irq(irq)
    );

    // access decode for the receive take and the transmit strobe
    always_comb begin
        take    = bus_rd && (bus_addr == ADDR_W'(IDX_RXD));
        tx_fire = bus_wr && (bus_addr == ADDR_W'(IDX_TXD)) && ctl2[B_TXEN];
    end

    // read multiplexer over all mapped words
    always_comb begin
        rd_word = '0;
        case (bus_addr)
            ADDR_W'(IDX_RXD):  rd_word = hold | (REG_W'(pending) << B_CHRDY);
            ADDR_W'(IDX_CTL1): rd_word = ctl1;
            ADDR_W'(IDX_CTL2): rd_word = ctl2;
            ADDR_W'(IDX_CTL3): rd_word = ctl3;
            ADDR_W'(IDX_FIFO): rd_word = fifo_ctl;
            ADDR_W'(IDX_STA1): rd_word = REG_W'(STA1_FIXED) | (REG_W'(pending) << B_RRDY);
            ADDR_W'(IDX_STA2): rd_word = REG_W'(STA2_FIXED) | (REG_W'(pending) << B_RDR);
            ADDR_W'(IDX_BMOD): rd_word = bmod;
            ADDR_W'(IDX_BCNT): rd_word = bcnt;
            ADDR_W'(IDX_MSEC): rd_word = msec;
            ADDR_W'(IDX_TEST): rd_word = REG_W'(TEST_FIXED) | (REG_W'(!pending) << B_RXEMPTY);
            default:           rd_word = '0;
        endcase
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= DATA_W'(rd_word);
    end

    // transmit strobe and byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_byte <= bus_wdata[CHAR_W-1:0];
        end
    end

endmodule

// File: rtl/uart_regfile_chk.sv
// Port-level protocol checker for uart_regfile, attached with bind.
module uart_regfile_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_retry,
    input logic              brk_evt
);

    logic srst_wr;
    // soft reset request seen at the ports
    always_comb srst_wr = bus_wr && bus_addr == ADDR_W'('h21) && !bus_wdata[0];

    assert_rx_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && !srst_wr |=> !rx_ready);

    assert_brk_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt && !srst_wr |=> !rx_ready);

    assert_read_consumes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == '0 && !rx_ready && !brk_evt |=> rx_ready && bus_rdata[15]);

    assert_srst_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> rx_ready);

    assert_tx_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && bus_addr == ADDR_W'('h10)));

    assert_retry_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_retry |-> $past(bus_wr && bus_addr == ADDR_W'('h21) && bus_wdata[1]));

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd && $past(rst_n) |=> $stable(bus_rdata));

endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_retry(rx_retry), .brk_evt(brk_evt)
);

// File: tb/sim_uart_regfile.sv
// Self-checking bench: directed corners then seeded random operations,
// compared against a reference model held in bench variables.
module sim_uart_regfile;

    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          tx_valid, rx_ready, rx_retry, irq;
    logic [7:0]    tx_byte;
    logic          rx_valid = 1'b0, brk_evt = 1'b0;
    logic [7:0]    rx_char = '0;

    always #4 clk = ~clk;

    uart_regfile #(.ADDR_W(AW), .DATA_W(DW), .REG_W(16), .CHAR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_char(rx_char), .rx_ready(rx_ready), .rx_retry(rx_retry),
        .brk_evt(brk_evt), .irq(irq)
    );

    int n_chk = 0, n_err = 0;
    int exp_tx = 0, got_tx = 0, exp_retry = 0, got_retry = 0;
    logic [7:0]  last_tx = '0, exp_byte = '0;
    logic [15:0] m_ctl1, m_ctl2, m_ctl3, m_fifo, m_bmod, m_bcnt, m_msec, m_hold;
    logic        m_pend;
    logic [31:0] last_rd = '0;
    bit          done = 0;

    // output monitors sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin got_tx++; last_tx = tx_byte; end
            if (rx_retry) got_retry++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model: soft reset effect
    task automatic model_srst();
        m_ctl1 = 16'h0; m_ctl3 = 16'h0700; m_bmod = 16'h0; m_bcnt = 16'h4;
        m_hold = 16'h4000; m_pend = 1'b0;
    endtask

    function automatic logic model_irq();
        return (m_pend && m_ctl1[9]) || m_ctl1[6];
    endfunction

    function automatic logic [31:0] model_peek(input int idx);
        case (idx)
            'h00: return {16'h0, m_hold | (m_pend ? 16'h8000 : 16'h0)};
            'h20: return {16'h0, m_ctl1};
            'h21: return {16'h0, m_ctl2};
            'h22: return {16'h0, m_ctl3};
            'h24: return {16'h0, m_fifo};
            'h25: return {16'h0, 16'h3040 | (m_pend ? 16'h0200 : 16'h0)};
            'h26: return {16'h0, 16'h4028 | (m_pend ? 16'h0001 : 16'h0)};
            'h2A: return {16'h0, m_bmod};
            'h2B: return {16'h0, m_bcnt};
            'h2C: return {16'h0, m_msec};
            'h2D: return {16'h0, 16'h0040 | (m_pend ? 16'h0 : 16'h0020)};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [31:0] d);
        logic old_rxen;
        case (idx)
            'h10: if (m_ctl2[2]) begin exp_tx++; exp_byte = d[7:0]; end
            'h20: m_ctl1 = d[15:0];
            'h21: begin
                old_rxen = m_ctl2[1];
                if (!d[0]) begin model_srst(); old_rxen = 1'b0; end
                if (d[1] && !old_rxen) exp_retry++;
                m_ctl2 = d[15:0] | 16'h1;
            end
            'h22: m_ctl3 = d[15:0];
            'h24: m_fifo = d[15:0];
            'h29: m_bcnt = d[15:0];
            'h2A: m_bmod = d[15:0];
            'h2C: m_msec = d[15:0];
            default: ;
        endcase
    endtask

    task automatic post_checks(input string req);
        #1;
        check({req, " irq R6"}, {31'h0, irq}, {31'h0, model_irq()});
        check({req, " rx_ready R4"}, {31'h0, rx_ready}, {31'h0, !m_pend});
        check({req, " tx count R7"}, got_tx, exp_tx);
        if (got_tx > 0) check({req, " tx byte R7"}, {24'h0, last_tx}, {24'h0, exp_byte});
        check({req, " retry R12"}, got_retry, exp_retry);
        check({req, " rdata hold R13"}, bus_rdata, last_rd);
    endtask

    task automatic do_wr(input int idx, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr = AW'(idx); bus_wdata = d; bus_wr = 1'b1;
        model_write(idx, d);
        @(negedge clk);
        bus_wr = 1'b0;
        post_checks(req);
    endtask

    task automatic do_rd(input int idx, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr = AW'(idx); bus_rd = 1'b1;
        exp = model_peek(idx);
        if (idx == 0) m_pend = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        last_rd = exp;
        check({req, " read R13"}, bus_rdata, exp);
        post_checks(req);
    endtask

    task automatic push_rx(input logic [7:0] ch, input string req);
        @(negedge clk);
        check({req, " ready before R4"}, {31'h0, rx_ready}, {31'h0, !m_pend});
        rx_valid = 1'b1; rx_char = ch;
        if (!m_pend) begin m_hold = {8'h0, ch}; m_pend = 1'b1; end
        @(negedge clk);
        rx_valid = 1'b0;
        post_checks(req);
    endtask

    task automatic push_brk(input string req);
        @(negedge clk);
        brk_evt = 1'b1;
        m_hold = 16'h0800; m_pend = 1'b1;
        @(negedge clk);
        brk_evt = 1'b0;
        post_checks(req);
    endtask

    // watchdog ends a hung run as a failure
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int map[15] = '{'h00, 'h10, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25,
                        'h26, 'h29, 'h2A, 'h2B, 'h2C, 'h2D, 'h3F};
        void'($urandom(32'd20240611));
        m_ctl2 = 16'h1; m_fifo = 16'h0; m_msec = 16'h0;
        model_srst();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        post_checks("reset R1");

        // R1 / R2 / R10: every index after reset, including unmapped ones
        for (int i = 0; i < 15; i++) do_rd(map[i], "reset value R1 R2");
        do_rd('h1FF, "unmapped R10");

        // R7: transmit dropped while TX-enable is clear
        do_wr('h10, 32'h0000_0033, "tx disabled R7");
        // R12: RX-enable rise, then TX enabled
        do_wr('h21, 32'h0000_0007, "rx enable rise R12");
        do_wr('h21, 32'h0000_0007, "rx enable held R12");
        do_wr('h10, 32'hFFFF_01A5, "tx byte R7");

        // R4 / R3: receive, refuse second, read consumes
        push_rx(8'h5A, "rx accept R4");
        do_rd('h25, "status1 rrdy R4");
        do_rd('h2D, "test rx-empty clear R4");
        push_rx(8'hC3, "rx refused R4");
        do_rd('h00, "rx read consume R3");
        do_rd('h00, "rx reread no chrdy R3");
        do_rd('h26, "status2 after take R3");

        // R5: break overwrites a pending character
        push_rx(8'h11, "rx before break R5");
        push_brk("break overwrite R5");
        do_rd('h00, "break code R5");

        // R6: interrupt enables
        push_rx(8'h22, "rx for irq R6");
        do_wr('h20, 32'h0000_2000, "trdy enable alone R6");
        do_wr('h20, 32'h0000_0200, "rrdy enable R6");
        do_rd('h00, "irq falls on take R6");
        do_wr('h20, 32'h0000_0040, "tx-empty enable R6");
        do_wr('h20, 32'h0000_0000, "irq off R6");

        // R9: status and test writes ignored
        push_rx(8'h44, "rx for status R9");
        do_wr('h25, 32'hFFFF_FFFF, "status1 w1c R9");
        do_wr('h26, 32'hFFFF_FFFF, "status2 w1c R9");
        do_wr('h2D, 32'hFFFF_FFFF, "test write R9");
        do_rd('h25, "status1 kept R9");
        do_rd('h26, "status2 kept R9");
        do_rd('h2D, "test kept R9");

        // R10: truncation and ignored control 4
        do_wr('h22, 32'hABCD_1234, "ctl3 trunc R10");
        do_rd('h22, "ctl3 read R10");
        do_wr('h23, 32'h0000_FFFF, "ctl4 write R10");
        do_rd('h23, "ctl4 zero R10");

        // R11: increment lands in count, count index read-only
        do_wr('h29, 32'h5555_0123, "binc write R11");
        do_rd('h2B, "bcnt from binc R11");
        do_rd('h29, "binc reads zero R11");
        do_wr('h2B, 32'h0000_0999, "bcnt write ignored R11");
        do_rd('h2B, "bcnt unchanged R11");

        // R8: soft reset keeps FIFO control and millisecond word
        do_wr('h24, 32'h0000_0A0B, "fifo set R8");
        do_wr('h2C, 32'h0000_03E8, "msec set R8");
        do_wr('h2A, 32'h0000_0077, "bmod set R8");
        do_wr('h21, 32'h0000_0002, "soft reset with rxen R8 R12");
        for (int i = 0; i < 15; i++) do_rd(map[i], "after soft reset R8");

        // random mix against the model
        for (int n = 0; n < 800; n++) begin
            int sel, idx;
            logic [31:0] d;
            sel = int'($urandom % 10);
            idx = map[$urandom % 15];
            d   = $urandom;
            if (idx == 'h21) d[0] = ($urandom % 8) != 0;
            if (sel < 4)       do_wr(idx, d, "random write");
            else if (sel < 7)  do_rd(idx, "random read");
            else if (sel < 9)  push_rx(d[7:0], "random rx R4");
            else               push_brk("random break R5");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule